// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte-wide MAC receive stream into memory buffers chosen by a ring of two-word descriptors. Each descriptor holds an address word and a status word. The address word gives a word-aligned buffer address. Its two low bits carry the hand-over flag (bit 0) and the end-of-ring flag (bit 1). Software loads the ring base through a pointer-load strobe and turns reception on with an enable input. The block then fetches the current descriptor and packs the frame bytes into 32-bit words, which it writes to the buffer. For a good frame it writes the status word and then writes the address word back with bit 0 set, so the buffer passes to software.

Frames that the MAC marks bad are not handed over, and the same descriptor takes the next frame. If a fetched descriptor is still owned by software, the block raises a no-buffer interrupt and halts. While halted it accepts and discards incoming bytes. Dropping the enable and raising it again resumes at the same descriptor. Completion and no-buffer events are sticky interrupt bits that are cleared by writing 1. Memory is reached through a single-request port that is held until it is acknowledged.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, `irq_status` is 0, `irq` is 0, `mem_req` is 0, and the descriptor index points at the ring base.
- R2: Byte k of a stored frame lands in bits [8*(k%4)+7 : 8*(k%4)] of the word at buffer address + 4*(k/4). Unused lanes of the final word are zero.
- R3: Descriptor i is read as the address word at base + 8*i. The buffer address is that word with bits [1:0] cleared. The write-back of the address word keeps the buffer address and the wrap flag (bit 1) and sets bit 0.
- R4: For a good frame, the word at base + 8*i + 4 is written with the byte count in bits [LEN_W-1:0], counting the 4 trailing CRC bytes. This write happens before the address word is written back.
- R5: Completing a frame sets `irq_status[0]`. Each `irq_status` bit stays set until 1 is written to it on `irq_clr`, and a set in the same cycle wins over a clear. `irq` is the OR of the bits.
- R6: If bit 0 of a fetched address word is already 1, the block sets `irq_status[1]` and halts. While halted it makes no memory request and drops incoming frames with `rx_ready` high. Driving `rx_en` low and then high resumes reception at the same descriptor.
- R7: Bytes beyond MAX_LEN are discarded. The status word then reports a length of MAX_LEN and sets bit 31.
- R8: Once `mem_req` is raised, it stays high with stable address, direction and write data until `mem_ack`.
- R9: After the descriptor with bit 1 set, or after descriptor DEPTH-1, the next descriptor is descriptor 0 at the ring base.
- R10: A frame whose `rx_good` is low at its last byte causes no status or address write-back and no completion interrupt. The same descriptor receives the next frame.
- R11: A pulse on `qp_wr` loads the ring base from `qp_data` (aligned to 8 bytes) and returns the index to descriptor 0.
- R12: While `rx_en` is low, `rx_ready` is high, bytes are dropped and no memory request is made. A disable that arrives before the first byte of a frame leaves the fetched descriptor untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Reception enable |
| qp_wr | input | 1 | Ring base load strobe |
| qp_data | input | ADDR_W | Ring base value |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of frame |
| rx_good | input | 1 | Frame good, sampled with the last byte |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| irq_clr | input | 2 | Write-1-to-clear for irq_status |
| irq_status | output | 2 | Bit 0 frame stored, bit 1 no buffer |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps frame lengths from 1 to MAX_LEN+3 over a three-entry ring ended by the wrap flag. This shows whether lane packing and zero padding are correct for every remainder modulo 4, and it separates exact fill from truncation. A second ring ends without any wrap flag, which tells the flag-driven return apart from the depth-driven one, and it also tests the base reload. Further cases cover a bad frame followed by a good one on the same descriptor, a ring left full so that a no-buffer halt occurs, a dropped frame while halted, and the enable toggle that resumes at the same descriptor. A frame sent while the block is disabled must leave memory untouched.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_RECV,
      S_WDATA,
      S_WSTAT,
      S_WOWN,
      S_HALT
   } rxd_state_e;

   localparam int OWN_BIT  = 0;
   localparam int WRAP_BIT = 1;
   localparam int OVF_BIT  = 31;
   localparam int IRQ_RCOM = 0;
   localparam int IRQ_BNA  = 1;
   localparam int IRQ_N    = 2;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_base,
   input  logic              advance,
   input  logic              wrap,
   output logic [ADDR_W-1:0] desc_addr
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         base_q <= load_base & ~ADDR_W'(7);
         idx_q  <= '0;
      end else if (advance) begin
         if (wrap || idx_q == IDX_W'(DEPTH - 1))
            idx_q <= '0;
         else
            idx_q <= idx_q + 1'b1;
      end
   end

   assign desc_addr = base_q + (ADDR_W'(idx_q) << 3);
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               take,
   input  logic [7:0]         din,
   output logic [8*LANES-1:0] word,
   output logic [2:0]         lanes
);
   logic [2:0] fill_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (clear)
            lane_q <= '0;
         else if (take && fill_q == 3'(g))
            lane_q <= din;
      end
      assign word[8*g +: 8] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fill_q <= '0;
      else if (clear)
         fill_q <= '0;
      else if (take)
         fill_q <= fill_q + 1'b1;
   end

   assign lanes = fill_q;
endmodule

// File: rtl/rxd_irq.sv
module rxd_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= '0;
      else
         status <= (status & ~clr) | set;
   end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
   import rxd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DEPTH   = 64,
   parameter int MAX_LEN = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              qp_wr,
   input  logic [ADDR_W-1:0] qp_data,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   input  logic              rx_good,
   output logic              rx_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic [IRQ_N-1:0]  irq_clr,
   output logic [IRQ_N-1:0]  irq_status,
   output logic              irq
);
   localparam int LEN_W = $clog2(MAX_LEN + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rx_ring_dma: DEPTH must be at least 2");
   end
   if (MAX_LEN < 4 || (MAX_LEN % 4) != 0) begin : g_bad_len
      $error("rx_ring_dma: MAX_LEN must be a positive multiple of 4");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("rx_ring_dma: ADDR_W must lie in 8..32");
   end

   rxd_state_e        state;
   logic [ADDR_W-1:0] buf_base, wr_off, desc_addr;
   logic              wrap_q, ovf_q, last_q, bad_q, drop_mid;
   logic [LEN_W-1:0]  cnt;
   logic [31:0]       pack_word, stat_word, own_word;
   logic [2:0]        lanes, lanes_after;
   logic              discard, take_byte, pack_clear, advance;
   logic [IRQ_N-1:0]  irq_set;

   rxd_ring_ptr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(qp_wr), .load_base(qp_data),
      .advance(advance), .wrap(wrap_q), .desc_addr(desc_addr)
   );

   rxd_packer #(.LANES(4)) u_pack (
      .clk(clk), .rst_n(rst_n), .clear(pack_clear), .take(take_byte),
      .din(rx_data), .word(pack_word), .lanes(lanes)
   );

   rxd_irq #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr),
      .status(irq_status)
   );

   always_comb begin
      discard     = (state == S_IDLE && (!rx_en || drop_mid)) || state == S_HALT;
      rx_ready    = discard || (state == S_RECV && lanes != 3'd4);
      take_byte   = state == S_RECV && rx_valid && rx_ready && cnt < LEN_W'(MAX_LEN);
      lanes_after = lanes + {2'b00, take_byte};
      pack_clear  = mem_ack && (state == S_FETCH || state == S_WDATA);
      advance     = state == S_WOWN && mem_ack;
      irq_set                = '0;
      irq_set[IRQ_RCOM]      = advance;
      irq_set[IRQ_BNA]       = state == S_FETCH && mem_ack && mem_rdata[OWN_BIT];

      stat_word              = '0;
      stat_word[LEN_W-1:0]   = cnt;
      stat_word[OVF_BIT]     = ovf_q;
      own_word               = 32'(buf_base);
      own_word[WRAP_BIT]     = wrap_q;
      own_word[OWN_BIT]      = 1'b1;

      mem_req   = 1'b0;
      mem_we    = 1'b1;
      mem_addr  = desc_addr;
      mem_wdata = own_word;
      unique case (state)
         S_FETCH: begin mem_req = 1'b1; mem_we = 1'b0; end
         S_WDATA: begin
            mem_req   = 1'b1;
            mem_addr  = buf_base + wr_off;
            mem_wdata = pack_word;
         end
         S_WSTAT: begin
            mem_req   = 1'b1;
            mem_addr  = desc_addr + ADDR_W'(4);
            mem_wdata = stat_word;
         end
         S_WOWN:  mem_req = 1'b1;
         default: ;
      endcase
   end

   assign irq = |irq_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         buf_base <= '0;
         wr_off   <= '0;
         wrap_q   <= 1'b0;
         ovf_q    <= 1'b0;
         last_q   <= 1'b0;
         bad_q    <= 1'b0;
         drop_mid <= 1'b0;
         cnt      <= '0;
      end else begin
         if (discard && rx_valid)
            drop_mid <= !rx_last;
         unique case (state)
            S_IDLE:
               if (rx_en && !drop_mid) state <= S_FETCH;
            S_HALT:
               if (!rx_en) state <= S_IDLE;
            S_FETCH:
               if (mem_ack) begin
                  if (mem_rdata[OWN_BIT]) begin
                     state <= S_HALT;
                  end else begin
                     buf_base <= mem_rdata[ADDR_W-1:0] & ~ADDR_W'(3);
                     wrap_q   <= mem_rdata[WRAP_BIT];
                     cnt      <= '0;
                     ovf_q    <= 1'b0;
                     last_q   <= 1'b0;
                     wr_off   <= '0;
                     state    <= S_RECV;
                  end
               end
            S_RECV:
               if (rx_valid && rx_ready) begin
                  if (take_byte) cnt <= cnt + 1'b1;
                  else           ovf_q <= 1'b1;
                  if (rx_last) begin
                     last_q <= 1'b1;
                     bad_q  <= !rx_good;
                     if (lanes_after != 3'd0) begin
                        state <= S_WDATA;
                     end else if (!rx_good) begin
                        cnt    <= '0;
                        ovf_q  <= 1'b0;
                        last_q <= 1'b0;
                        wr_off <= '0;
                     end else begin
                        state <= S_WSTAT;
                     end
                  end else if (lanes_after == 3'd4) begin
                     state <= S_WDATA;
                  end
               end else if (!rx_en && cnt == '0 && !ovf_q) begin
                  state <= S_IDLE;
               end
            S_WDATA:
               if (mem_ack) begin
                  wr_off <= wr_off + ADDR_W'(4);
                  if (!last_q) begin
                     state <= S_RECV;
                  end else if (bad_q) begin
                     cnt    <= '0;
                     ovf_q  <= 1'b0;
                     last_q <= 1'b0;
                     wr_off <= '0;
                     state  <= S_RECV;
                  end else begin
                     state <= S_WSTAT;
                  end
               end
            S_WSTAT:
               if (mem_ack) state <= S_WOWN;
            S_WOWN:
               if (mem_ack) begin
                  last_q <= 1'b0;
                  state  <= S_IDLE;
               end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
   import rxd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 12,
   parameter int MAX_LEN = 2048
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic [31:0]       mem_rdata,
   input logic [1:0]        irq_status,
   input rxd_state_e        st
);
   logic [ADDR_W-1:0] last_wr_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_wr_addr <= '0;
      else if (mem_req && mem_we && mem_ack)
         last_wr_addr <= mem_addr;
   end

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R4
   status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WOWN && mem_ack) |-> (last_wr_addr == mem_addr + ADDR_W'(4)));

   // R5
   rcom_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[0]) |-> $past(st == S_WOWN && mem_ack));

   // R6
   bna_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[1]) |-> $past(st == S_FETCH && mem_ack && mem_rdata[0]));

   // R6
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HALT) |-> !mem_req);

   // R7
   ovf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WSTAT && mem_req && mem_wdata[31]) |-> (mem_wdata[LEN_W-1:0] == LEN_W'(MAX_LEN)));
endmodule

bind rx_ring_dma rxd_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
   .irq_status(irq_status), .st(state)
);

// File: tb/rx_ring_dma_test.sv
module rx_ring_dma_test;
   localparam int AW = 16;
   localparam int MAXL = 16;

   logic clk = 0, rst_n = 0, rx_en = 0, qp_wr = 0;
   logic [AW-1:0] qp_data = '0;
   logic rx_valid = 0, rx_last = 0, rx_good = 0;
   logic [7:0] rx_data = '0;
   logic rx_ready, mem_req, mem_we, irq;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic mem_ack;
   logic [1:0] irq_clr = '0, irq_status;

   logic [31:0] mem [0:255];
   logic tb_wr = 0;
   logic [7:0] tb_a = '0;
   logic [31:0] tb_d = '0;
   int wr_seen = 0, req_seen = 0;
   int errors = 0, checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rx_ring_dma #(.ADDR_W(AW), .DEPTH(4), .MAX_LEN(MAXL)) uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .qp_wr(qp_wr), .qp_data(qp_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_good(rx_good),
      .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= '0;
         mem_ack <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req) req_seen <= req_seen + 1;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr[9:2]] <= mem_wdata;
               wr_seen <= wr_seen + 1;
            end else begin
               mem_rdata <= mem[mem_addr[9:2]];
            end
         end
         if (tb_wr) mem[tb_a] <= tb_d;
      end
   end

   function automatic logic [7:0] fb(int id, int k);
      return 8'(id * 37 + k * 5 + 1);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic mem_write(int addr, logic [31:0] d);
      @(negedge clk);
      tb_wr = 1; tb_a = 8'(addr >> 2); tb_d = d;
      @(negedge clk);
      tb_wr = 0;
   endtask

   task automatic load_qp(int base);
      @(negedge clk);
      qp_wr = 1; qp_data = AW'(base);
      @(negedge clk);
      qp_wr = 0;
   endtask

   task automatic send_frame(int len, int id, bit good);
      @(negedge clk);
      for (int k = 0; k < len; k++) begin
         rx_valid = 1; rx_data = fb(id, k); rx_last = (k == len - 1); rx_good = good;
         while (!rx_ready) @(negedge clk);
         @(negedge clk);
      end
      rx_valid = 0; rx_last = 0;
   endtask

   task automatic wait_bit(int b, output bit seen);
      seen = 0;
      for (int i = 0; i < 300 && !seen; i++) begin
         @(negedge clk);
         if (irq_status[b]) seen = 1;
      end
   endtask

   task automatic clear_irq(logic [1:0] m);
      @(negedge clk);
      irq_clr = m;
      @(negedge clk);
      irq_clr = '0;
   endtask

   task automatic check_frame(int da, int bufa, bit wr, int len, int id, string tag);
      int stored;
      bit seen;
      logic [31:0] exp;
      stored = (len > MAXL) ? MAXL : len;
      wait_bit(0, seen);
      chk({tag, "/R5 rcom"}, 32'(seen), 1);
      exp = 32'(stored) | ((len > MAXL) ? 32'h8000_0000 : 32'h0);
      chk({tag, (len > MAXL) ? "/R7 status" : "/R4 status"}, mem[(da + 4) >> 2], exp);
      chk({tag, "/R3 owner word"}, mem[da >> 2], 32'(bufa) | (32'(wr) << 1) | 32'h1);
      for (int j = 0; j < (stored + 3) / 4; j++) begin
         exp = '0;
         for (int b = 0; b < 4; b++)
            if (4 * j + b < stored) exp |= 32'(fb(id, 4 * j + b)) << (8 * b);
         chk({tag, "/R2 data"}, mem[(bufa >> 2) + j], exp);
      end
      clear_irq(2'b01);
      chk({tag, "/R5 clear"}, {30'b0, irq_status[0], irq}, {30'b0, 1'b0, irq_status[1]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      int w0, s_old, a_old;
      bit seen;
      repeat (4) @(negedge clk);
      chk("R1 irq_status", {30'b0, irq_status}, 0);
      chk("R1 mem_req", {31'b0, mem_req}, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R12 ready disabled", {31'b0, rx_ready}, 1);

      // ring A: base 0x40, three used entries, wrap flag on entry 2
      for (int i = 0; i < 3; i++)
         mem_write(32'h40 + 8 * i, 32'h100 + 32'h20 * i + ((i == 2) ? 32'h2 : 32'h0));

      // R12: frame while disabled leaves memory alone
      w0 = req_seen;
      send_frame(6, 99, 1);
      repeat (10) @(negedge clk);
      chk("R12 no request", 32'(req_seen - w0), 0);
      chk("R12 buffer untouched", mem[32'h100 >> 2], 0);

      load_qp(32'h40);
      rx_en = 1;
      // R2 R4 R7 R9 sweep of all lengths through truncation
      for (int L = 1; L <= MAXL + 3; L++) begin
         int d;
         d = (L - 1) % 3;
         send_frame(L, L, 1);
         check_frame(32'h40 + 8 * d, 32'h100 + 32'h20 * d, d == 2, L, L, "R9 sweep");
         mem_write(32'h40 + 8 * d, 32'h100 + 32'h20 * d + ((d == 2) ? 32'h2 : 32'h0));
      end

      // R10: bad frame on entry (19 % 3) = 1, then good frame on the same entry
      s_old = mem[(32'h48 + 4) >> 2];
      a_old = mem[32'h48 >> 2];
      send_frame(6, 40, 0);
      repeat (40) @(negedge clk);
      chk("R10 no rcom", {30'b0, irq_status}, 0);
      chk("R10 status kept", mem[(32'h48 + 4) >> 2], s_old);
      chk("R10 addr kept", mem[32'h48 >> 2], a_old);
      send_frame(5, 50, 1);
      check_frame(32'h48, 32'h120, 0, 5, 50, "R10 reuse");

      // R11: disable before the next frame, reload base to ring B
      rx_en = 0;
      repeat (6) @(negedge clk);
      for (int i = 0; i < 4; i++)
         mem_write(32'h80 + 8 * i, 32'h180 + 32'h20 * i);
      load_qp(32'h80);
      rx_en = 1;
      for (int i = 0; i < 4; i++) begin
         send_frame(4 + 3 * i, 60 + i, 1);
         check_frame(32'h80 + 8 * i, 32'h180 + 32'h20 * i, 0, 4 + 3 * i, 60 + i, i == 0 ? "R11 base" : "R9 depth");
      end

      // R6: entry 0 still owned, halt
      wait_bit(1, seen);
      chk("R6 bna set", 32'(seen), 1);
      chk("R5 irq or", {31'b0, irq}, 1);
      repeat (3) @(negedge clk);
      w0 = req_seen;
      send_frame(7, 70, 1);
      repeat (20) @(negedge clk);
      chk("R6 halted no request", 32'(req_seen - w0), 0);
      chk("R6 dropped status", mem[(32'h80 + 4) >> 2], 32'd4);
      chk("R6 no rcom", {31'b0, irq_status[0]}, 0);
      mem_write(32'h80, 32'h180);
      rx_en = 0;
      repeat (3) @(negedge clk);
      rx_en = 1;
      send_frame(9, 71, 1);
      check_frame(32'h80, 32'h180, 0, 9, 71, "R6 resume");
      repeat (20) @(negedge clk);
      clear_irq(2'b10);
      chk("R5 bna clear", {30'b0, irq_status}, 0);
      summary();
   end
endmodule